// File: doc/BRIEF.md
# Speculative Access Tracker

This block records which of four ordered speculative threads has read or written each word of every memory line touched during a speculative section. Each thread runs on its own processor. The threads are ordered by speculation, starting at a head processor, which is the least speculative, and wrapping modulo four. Each tracked line takes one entry in a set-associative table. The entry holds a tag, a valid flag, and a read bit and a write bit for every word and every processor.

When a processor misses its private cache, it sends a request through a valid/ready channel. For a read, the block reports which processor holds the newest version of that word visible to the requester. If no such processor exists, it reports that the safe copy supplies the data. For a write, the block reports which more-speculative threads consumed stale data and must be squashed. A write by a thread that sits between the writer and a reader protects that reader.

A separate valid/ready maintenance channel handles two operations. It retires the head thread on commit, or it squashes a thread together with every thread more speculative than it. Either operation clears that thread's bits by walking the table one set per cycle.

Top module: `spec_access_tracker`

## Requirements
- R1: A request is accepted on a rising edge with `req_valid` and `req_ready` high. `req_is_store`=1 marks a write and 0 marks a read. The line address splits into set index (low `SET_W` bits) and tag (upper bits). The access sets the requester's read or write bit for word `req_word` in that line's entry. If the line has no entry, a free way is allocated.
- R2: For a read, the response names the source of the data. The source is the processor nearest to the requester, counting down the speculation order and including the requester itself, whose write bit is set for that word. In that case `rsp_from_spec`=1 and `rsp_src_proc` holds that processor. If no such processor exists, `rsp_from_spec`=0, meaning the safe copy.
- R3: For a write, bit i of `rsp_squash` is set when processor i is more speculative than the writer and has its read bit set for the same word.
- R4: A reader is left out of the squash mask when a processor strictly between the writer and the reader has its write bit set for that word.
- R5: Three kinds of access never squash: a write followed by a more-speculative write, a write that lands on a word read only by less-speculative threads, and accesses to different words of one line. Read responses always carry `rsp_squash`=0.
- R6: A request to an untracked line whose set has no free way returns `rsp_stall`=1. In that case nothing is recorded, the source is reported as the safe copy, and the squash mask is 0. Requests to lines already tracked in that set are still served.
- R7: Speculation order starts at `head_proc` and wraps modulo 4. For example, with head 1, processor 0 is the most speculative.
- R8: A commit (`maint_is_squash`=0) clears the head processor's bits in every entry. It reports `maint_mask` as a one-hot mask of the head and then advances `head_proc` by one. Entries left with no bits set become free.
- R9: A squash (`maint_is_squash`=1) of `maint_proc` clears the bits of that processor and of every processor more speculative than it. It reports them in `maint_mask` (bit i = processor i) and leaves `head_proc` unchanged.
- R10: While a maintenance walk runs, `req_ready` and `maint_ready` are both low. `req_ready` is also low while `maint_valid` is high. `maint_ready` is low while a request is still in flight.
- R11: For a request accepted at edge n, `rsp_valid` is high for exactly the one cycle that follows edge n+1. `maint_done` pulses for one cycle when a walk ends.
- R12: After reset, the table is empty, `head_proc` is 0, `rsp_valid` and `maint_done` are low, and both ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request can be taken |
| req_is_store | input | 1 | 1 = write, 0 = read |
| req_proc | input | 2 | Requesting processor |
| req_line | input | 20 | Line address |
| req_word | input | 4 | Word within the line |
| rsp_valid | output | 1 | Response strobe |
| rsp_proc | output | 2 | Requester echoed |
| rsp_is_store | output | 1 | Access kind echoed |
| rsp_stall | output | 1 | Set full, access not recorded |
| rsp_from_spec | output | 1 | 1 = speculative version, 0 = safe copy |
| rsp_src_proc | output | 2 | Processor supplying the version |
| rsp_squash | output | 4 | Threads to squash |
| maint_valid | input | 1 | Maintenance request present |
| maint_ready | output | 1 | Maintenance can be taken |
| maint_is_squash | input | 1 | 1 = squash, 0 = commit head |
| maint_proc | input | 2 | Processor to squash |
| maint_done | output | 1 | Walk finished strobe |
| maint_mask | output | 4 | Processors cleared |
| head_proc | output | 2 | Least-speculative processor |

## Verification
A corrupted read or write bit shows up at the next access to that word. For a read, it appears as a wrong source processor. For a write, it appears as an extra or missing squash bit. In both cases the error reaches the port one cycle after acceptance. A wrong head pointer changes every order-dependent answer at once. A bit that a walk fails to clear only shows later, when a read that should be served by the safe copy names a retired processor. A set whose entries are never freed shows as a stall on the first new line after a commit. For that reason the tests follow each commit and squash with reads that depend on the cleared state.

// File: rtl/spec_trk_pkg.sv
package spec_trk_pkg;
  typedef enum logic {ACC_READ = 1'b0, ACC_WRITE = 1'b1} acc_kind_e;
  typedef enum logic {MNT_COMMIT = 1'b0, MNT_SQUASH = 1'b1} mnt_kind_e;
endpackage

// File: rtl/spec_trk_way_select.sv
module spec_trk_way_select #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 14,
  localparam int WW   = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]       way_vld,
  input  logic [WAYS*TAG_W-1:0] way_tags,
  input  logic [TAG_W-1:0]      look_tag,
  output logic                  hit,
  output logic [WW-1:0]         hit_way,
  output logic                  free_avail,
  output logic [WW-1:0]         free_way
);
  logic [WAYS-1:0] match_v;
  logic [WAYS-1:0] free_v;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_v[w] = way_vld[w] && (way_tags[w*TAG_W +: TAG_W] == look_tag);
    assign free_v[w]  = !way_vld[w];
  end

  always_comb begin
    hit        = 1'b0;
    hit_way    = '0;
    free_avail = 1'b0;
    free_way   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_v[w]) begin
        hit     = 1'b1;
        hit_way = WW'(w);
      end
      if (free_v[w]) begin
        free_avail = 1'b1;
        free_way   = WW'(w);
      end
    end
  end
endmodule

// File: rtl/spec_trk_resolve.sv
module spec_trk_resolve #(
  parameter int NPROC = 4,
  localparam int PW   = $clog2(NPROC)
) (
  input  logic [NPROC-1:0] rd_bits,
  input  logic [NPROC-1:0] wr_bits,
  input  logic [PW-1:0]    who,
  input  logic [PW-1:0]    head,
  output logic             src_found,
  output logic [PW-1:0]    src_proc,
  output logic [NPROC-1:0] victims
);
  logic [PW-1:0] my_rank;
  logic [PW-1:0] cand;
  logic          shield;

  assign my_rank = who - head;

  always_comb begin
    src_found = 1'b0;
    src_proc  = who;
    victims   = '0;
    cand      = '0;
    shield    = 1'b0;
    // walk downward in speculation order, nearest first
    for (int d = 0; d < NPROC; d++) begin
      cand = who - PW'(d);
      if (!src_found && (d <= int'(my_rank)) && wr_bits[cand]) begin
        src_found = 1'b1;
        src_proc  = cand;
      end
    end
    // walk upward; a writer seen on the way protects later readers
    for (int k = 1; k < NPROC; k++) begin
      cand = who + PW'(k);
      if (k <= (NPROC - 1) - int'(my_rank)) begin
        if (rd_bits[cand] && !shield) victims[cand] = 1'b1;
        if (wr_bits[cand]) shield = 1'b1;
      end
    end
  end
endmodule

// File: rtl/spec_trk_clear_mask.sv
module spec_trk_clear_mask #(
  parameter int NPROC = 4,
  localparam int PW   = $clog2(NPROC)
) (
  input  logic             is_squash,
  input  logic [PW-1:0]    target,
  input  logic [PW-1:0]    head,
  output logic [NPROC-1:0] mask
);
  logic [PW-1:0] tgt_rank;
  assign tgt_rank = target - head;

  for (genvar x = 0; x < NPROC; x++) begin : g_m
    logic [PW-1:0] rank_x;
    assign rank_x  = PW'(x) - head;
    assign mask[x] = is_squash ? (rank_x >= tgt_rank) : (PW'(x) == head);
  end
endmodule

// File: rtl/spec_access_tracker.sv
module spec_access_tracker #(
  parameter int NPROC  = 4,
  parameter int WORDS  = 16,
  parameter int SETS   = 64,
  parameter int WAYS   = 8,
  parameter int LINE_W = 20,
  localparam int PW    = $clog2(NPROC),
  localparam int WDW   = $clog2(WORDS),
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = LINE_W - SET_W,
  localparam int WW    = $clog2(WAYS),
  localparam int BITS  = WORDS * NPROC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_store,
  input  logic [PW-1:0]     req_proc,
  input  logic [LINE_W-1:0] req_line,
  input  logic [WDW-1:0]    req_word,
  output logic              rsp_valid,
  output logic [PW-1:0]     rsp_proc,
  output logic              rsp_is_store,
  output logic              rsp_stall,
  output logic              rsp_from_spec,
  output logic [PW-1:0]     rsp_src_proc,
  output logic [NPROC-1:0]  rsp_squash,
  input  logic              maint_valid,
  output logic              maint_ready,
  input  logic              maint_is_squash,
  input  logic [PW-1:0]     maint_proc,
  output logic              maint_done,
  output logic [NPROC-1:0]  maint_mask,
  output logic [PW-1:0]     head_proc
);
  import spec_trk_pkg::*;

  // table storage
  logic            ent_vld [SETS][WAYS];
  logic [TAG_W-1:0] ent_tag [SETS][WAYS];
  logic [BITS-1:0]  ent_rd  [SETS][WAYS];
  logic [BITS-1:0]  ent_wr  [SETS][WAYS];

  // access stage
  logic              s1_vld;
  acc_kind_e         s1_kind;
  logic [PW-1:0]     s1_proc;
  logic [LINE_W-1:0] s1_line;
  logic [WDW-1:0]    s1_word;
  logic [SET_W-1:0]  s1_set;
  logic [TAG_W-1:0]  s1_tag;

  // maintenance walk
  logic              walk_busy;
  logic [SET_W-1:0]  walk_idx;
  logic [NPROC-1:0]  walk_mask;
  mnt_kind_e         walk_kind;
  logic [NPROC-1:0]  new_mask;
  logic [BITS-1:0]   clr_vec;

  logic              req_fire;
  logic              mnt_fire;
  logic [SET_W-1:0]  rd_set;

  assign req_ready = !walk_busy && !maint_valid;
  assign maint_ready = !walk_busy && !s1_vld;
  assign req_fire = req_valid && req_ready;
  assign mnt_fire = maint_valid && maint_ready;
  assign s1_set = s1_line[SET_W-1:0];
  assign s1_tag = s1_line[LINE_W-1:SET_W];
  assign rd_set = walk_busy ? walk_idx : s1_set;

  // one row of the table, picked by the access stage or the walk
  logic [WAYS-1:0]       row_vld;
  logic [WAYS*TAG_W-1:0] row_tags;
  logic [BITS-1:0]       row_rd [WAYS];
  logic [BITS-1:0]       row_wr [WAYS];
  logic [BITS-1:0]       kept_rd [WAYS];
  logic [BITS-1:0]       kept_wr [WAYS];

  for (genvar p = 0; p < NPROC; p++) begin : g_clr
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      assign clr_vec[w*NPROC + p] = walk_mask[p];
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_row
    assign row_vld[w]                  = ent_vld[rd_set][w];
    assign row_tags[w*TAG_W +: TAG_W]  = ent_tag[rd_set][w];
    assign row_rd[w]                   = ent_rd[rd_set][w];
    assign row_wr[w]                   = ent_wr[rd_set][w];
    assign kept_rd[w]                  = row_rd[w] & ~clr_vec;
    assign kept_wr[w]                  = row_wr[w] & ~clr_vec;
  end

  logic          hit;
  logic [WW-1:0] hit_way;
  logic          free_avail;
  logic [WW-1:0] free_way;

  spec_trk_way_select #(.WAYS(WAYS), .TAG_W(TAG_W)) i_way_select (
    .way_vld   (row_vld),
    .way_tags  (row_tags),
    .look_tag  (s1_tag),
    .hit       (hit),
    .hit_way   (hit_way),
    .free_avail(free_avail),
    .free_way  (free_way)
  );

  logic [NPROC-1:0] word_rd;
  logic [NPROC-1:0] word_wr;
  logic             src_found;
  logic [PW-1:0]    src_proc;
  logic [NPROC-1:0] victims;

  always_comb begin
    for (int p = 0; p < NPROC; p++) begin
      word_rd[p] = hit && row_rd[hit_way][int'(s1_word) * NPROC + p];
      word_wr[p] = hit && row_wr[hit_way][int'(s1_word) * NPROC + p];
    end
  end

  spec_trk_resolve #(.NPROC(NPROC)) i_resolve (
    .rd_bits  (word_rd),
    .wr_bits  (word_wr),
    .who      (s1_proc),
    .head     (head_proc),
    .src_found(src_found),
    .src_proc (src_proc),
    .victims  (victims)
  );

  spec_trk_clear_mask #(.NPROC(NPROC)) i_clear_mask (
    .is_squash(maint_is_squash),
    .target   (maint_proc),
    .head     (head_proc),
    .mask     (new_mask)
  );

  // update of the selected entry
  logic            do_record;
  logic            set_full;
  logic [WW-1:0]   use_way;
  logic [BITS-1:0] my_bit;
  logic [BITS-1:0] base_rd;
  logic [BITS-1:0] base_wr;
  logic [BITS-1:0] upd_rd;
  logic [BITS-1:0] upd_wr;

  assign set_full  = !hit && !free_avail;
  assign do_record = s1_vld && !set_full;
  assign use_way   = hit ? hit_way : free_way;
  assign my_bit    = BITS'(1) << (int'(s1_word) * NPROC + int'(s1_proc));
  assign base_rd   = hit ? row_rd[hit_way] : '0;
  assign base_wr   = hit ? row_wr[hit_way] : '0;
  assign upd_rd    = (s1_kind == ACC_READ)  ? (base_rd | my_bit) : base_rd;
  assign upd_wr    = (s1_kind == ACC_WRITE) ? (base_wr | my_bit) : base_wr;

  // valid flags (reset)
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          ent_vld[s][w] <= 1'b0;
    end else if (walk_busy) begin
      for (int w = 0; w < WAYS; w++)
        ent_vld[walk_idx][w] <= row_vld[w] && (|(kept_rd[w] | kept_wr[w]));
    end else if (do_record) begin
      ent_vld[s1_set][use_way] <= 1'b1;
    end
  end

  // tags and bit vectors (no reset needed, guarded by valid)
  always_ff @(posedge clk) begin
    if (walk_busy) begin
      for (int w = 0; w < WAYS; w++) begin
        ent_rd[walk_idx][w] <= kept_rd[w];
        ent_wr[walk_idx][w] <= kept_wr[w];
      end
    end else if (do_record) begin
      ent_tag[s1_set][use_way] <= s1_tag;
      ent_rd[s1_set][use_way]  <= upd_rd;
      ent_wr[s1_set][use_way]  <= upd_wr;
    end
  end

  // access stage and response
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld        <= 1'b0;
      s1_kind       <= ACC_READ;
      s1_proc       <= '0;
      s1_line       <= '0;
      s1_word       <= '0;
      rsp_valid     <= 1'b0;
      rsp_proc      <= '0;
      rsp_is_store  <= 1'b0;
      rsp_stall     <= 1'b0;
      rsp_from_spec <= 1'b0;
      rsp_src_proc  <= '0;
      rsp_squash    <= '0;
    end else begin
      s1_vld <= req_fire;
      if (req_fire) begin
        s1_kind <= req_is_store ? ACC_WRITE : ACC_READ;
        s1_proc <= req_proc;
        s1_line <= req_line;
        s1_word <= req_word;
      end
      rsp_valid <= s1_vld;
      if (s1_vld) begin
        rsp_proc      <= s1_proc;
        rsp_is_store  <= (s1_kind == ACC_WRITE);
        rsp_stall     <= set_full;
        rsp_from_spec <= (s1_kind == ACC_READ) && src_found;
        rsp_src_proc  <= src_proc;
        rsp_squash    <= (s1_kind == ACC_WRITE) ? victims : '0;
      end
    end
  end

  // maintenance walk control
  always_ff @(posedge clk) begin
    if (rst) begin
      walk_busy  <= 1'b0;
      walk_idx   <= '0;
      walk_mask  <= '0;
      walk_kind  <= MNT_COMMIT;
      maint_done <= 1'b0;
      maint_mask <= '0;
      head_proc  <= '0;
    end else begin
      maint_done <= 1'b0;
      if (mnt_fire) begin
        walk_busy <= 1'b1;
        walk_idx  <= '0;
        walk_mask <= new_mask;
        walk_kind <= maint_is_squash ? MNT_SQUASH : MNT_COMMIT;
      end else if (walk_busy) begin
        walk_idx <= walk_idx + 1'b1;
        if (walk_idx == SET_W'(SETS - 1)) begin
          walk_busy  <= 1'b0;
          maint_done <= 1'b1;
          maint_mask <= walk_mask;
          if (walk_kind == MNT_COMMIT) head_proc <= head_proc + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spec_trk_checker.sv
module spec_trk_checker #(
  parameter int NPROC = 4,
  localparam int PW   = $clog2(NPROC)
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             maint_valid,
  input logic             maint_ready,
  input logic             rsp_valid,
  input logic [PW-1:0]    rsp_proc,
  input logic             rsp_is_store,
  input logic             rsp_stall,
  input logic             rsp_from_spec,
  input logic [PW-1:0]    rsp_src_proc,
  input logic [NPROC-1:0] rsp_squash,
  input logic             maint_done,
  input logic [NPROC-1:0] maint_mask,
  input logic [PW-1:0]    head_proc
);
  logic [NPROC-1:0] later_than_req;
  logic [PW-1:0]    req_rank;
  logic [PW-1:0]    src_rank;

  assign req_rank = rsp_proc - head_proc;
  assign src_rank = rsp_src_proc - head_proc;
  for (genvar x = 0; x < NPROC; x++) begin : g_l
    assign later_than_req[x] = (PW'(x) - head_proc) > req_rank;
  end

  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (rst)
    rsp_valid == $past(req_valid && req_ready, 2)); // R11
  AST_SQUASH_ONLY_LATER: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ((rsp_squash & ~later_than_req) == '0)); // R3
  AST_READ_NO_SQUASH: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_is_store) |-> (rsp_squash == '0)); // R5
  AST_SRC_NOT_LATER: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_from_spec) |-> (src_rank <= req_rank)); // R2
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_stall) |-> (!rsp_from_spec && rsp_squash == '0)); // R6
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (maint_valid && maint_ready) |=> (!req_ready && !maint_ready)); // R10
  AST_DONE_MASK: assert property (@(posedge clk) disable iff (rst)
    maint_done |-> (maint_mask != '0)); // R9
  AST_HEAD_MOVES_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    !$stable(head_proc) |-> (maint_done && $onehot(maint_mask))); // R8
  AST_ONE_SHOT_DONE: assert property (@(posedge clk) disable iff (rst)
    maint_done |=> !maint_done); // R11
endmodule

bind spec_access_tracker spec_trk_checker #(.NPROC(NPROC)) i_spec_trk_checker (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .maint_valid  (maint_valid),
  .maint_ready  (maint_ready),
  .rsp_valid    (rsp_valid),
  .rsp_proc     (rsp_proc),
  .rsp_is_store (rsp_is_store),
  .rsp_stall    (rsp_stall),
  .rsp_from_spec(rsp_from_spec),
  .rsp_src_proc (rsp_src_proc),
  .rsp_squash   (rsp_squash),
  .maint_done   (maint_done),
  .maint_mask   (maint_mask),
  .head_proc    (head_proc)
);

// File: tb/test_spec_access_tracker.sv
module test_spec_access_tracker;
  localparam int SETS = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_is_store = 1'b0;
  logic [1:0]  req_proc = '0;
  logic [19:0] req_line = '0;
  logic [3:0]  req_word = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_proc;
  logic        rsp_is_store;
  logic        rsp_stall;
  logic        rsp_from_spec;
  logic [1:0]  rsp_src_proc;
  logic [3:0]  rsp_squash;
  logic        maint_valid = 1'b0;
  logic        maint_ready;
  logic        maint_is_squash = 1'b0;
  logic [1:0]  maint_proc = '0;
  logic        maint_done;
  logic [3:0]  maint_mask;
  logic [1:0]  head_proc;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  spec_access_tracker i_spec_access_tracker (.*);

  function automatic logic [19:0] ln(input int tag, input int set);
    return 20'(tag * SETS + set);
  endfunction

  task automatic check(input string rq, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  // one access; checks latency and all response fields
  task automatic access(input string rq, input bit st, input int p, input logic [19:0] line,
                        input int w, input bit e_stall, input bit e_spec, input int e_src,
                        input int e_sq);
    @(negedge clk);
    check({rq, " R10 req_ready"}, int'(req_ready), 1);
    req_valid = 1'b1; req_is_store = st; req_proc = 2'(p); req_line = line; req_word = 4'(w);
    @(negedge clk);
    req_valid = 1'b0;
    check({rq, " R11 early rsp"}, int'(rsp_valid), 0);
    @(negedge clk);
    check({rq, " R11 rsp_valid"}, int'(rsp_valid), 1);
    check({rq, " stall"}, int'(rsp_stall), int'(e_stall));
    check({rq, " from_spec"}, int'(rsp_from_spec), int'(e_spec));
    if (e_spec) check({rq, " src"}, int'(rsp_src_proc), e_src);
    check({rq, " squash"}, int'(rsp_squash), e_sq);
    @(negedge clk);
    check({rq, " R11 pulse"}, int'(rsp_valid), 0);
  endtask

  task automatic maint(input string rq, input bit sq, input int p, input int e_mask, input int e_head);
    int waited;
    @(negedge clk);
    check({rq, " R10 maint_ready"}, int'(maint_ready), 1);
    maint_valid = 1'b1; maint_is_squash = sq; maint_proc = 2'(p);
    @(negedge clk);
    maint_valid = 1'b0;
    check({rq, " R10 req blocked"}, int'(req_ready), 0);
    check({rq, " R10 maint blocked"}, int'(maint_ready), 0);
    waited = 0;
    while (!maint_done && waited < 500) begin
      @(negedge clk);
      waited++;
    end
    check({rq, " done"}, int'(maint_done), 1);
    check({rq, " mask"}, int'(maint_mask), e_mask);
    check({rq, " head"}, int'(head_proc), e_head);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R12 rsp_valid", int'(rsp_valid), 0);
    check("R12 maint_done", int'(maint_done), 0);
    check("R12 req_ready", int'(req_ready), 1);
    check("R12 maint_ready", int'(maint_ready), 1);
    check("R12 head", int'(head_proc), 0);
  endtask

  task automatic t_load_source();
    access("R1 R2 untracked read", 0, 1, ln(1, 1), 0, 0, 0, 0, 0);
    access("R2 write P0", 1, 0, ln(1, 1), 3, 0, 0, 0, 0);
    access("R5 write P1 waw", 1, 1, ln(1, 1), 3, 0, 0, 0, 0);
    access("R2 P2 nearest writer", 0, 2, ln(1, 1), 3, 0, 1, 1, 0);
    access("R2 P0 own write", 0, 0, ln(1, 1), 3, 0, 1, 0, 0);
    access("R2 other word safe", 0, 1, ln(1, 1), 5, 0, 0, 0, 0);
  endtask

  task automatic t_raw();
    access("R3 P2 read w7", 0, 2, ln(1, 1), 7, 0, 0, 0, 0);
    access("R3 P0 write w7", 1, 0, ln(1, 1), 7, 0, 0, 0, 4'b0100);
  endtask

  task automatic t_shield();
    access("R4 P2 read w8", 0, 2, ln(1, 1), 8, 0, 0, 0, 0);
    access("R4 P3 read w8", 0, 3, ln(1, 1), 8, 0, 0, 0, 0);
    access("R4 P1 write w8", 1, 1, ln(1, 1), 8, 0, 0, 0, 4'b1100);
    access("R4 P0 write shielded", 1, 0, ln(1, 1), 8, 0, 0, 0, 0);
    access("R4 P1 read w10", 0, 1, ln(1, 1), 10, 0, 0, 0, 0);
    access("R4 P3 read w10", 0, 3, ln(1, 1), 10, 0, 0, 0, 0);
    access("R4 P2 write w10", 1, 2, ln(1, 1), 10, 0, 0, 0, 4'b1000);
    access("R4 P0 write partial", 1, 0, ln(1, 1), 10, 0, 0, 0, 4'b0010);
  endtask

  task automatic t_no_squash();
    access("R5 P0 read w11", 0, 0, ln(1, 1), 11, 0, 0, 0, 0);
    access("R5 war", 1, 2, ln(1, 1), 11, 0, 0, 0, 0);
    access("R5 P3 write w12", 1, 3, ln(1, 1), 12, 0, 0, 0, 0);
    access("R5 waw", 1, 1, ln(1, 1), 12, 0, 0, 0, 0);
    access("R5 P3 read w13", 0, 3, ln(1, 1), 13, 0, 0, 0, 0);
    access("R5 other word", 1, 0, ln(1, 1), 14, 0, 0, 0, 0);
  endtask

  task automatic t_commit();
    access("R8 P0 write B", 1, 0, ln(1, 2), 2, 0, 0, 0, 0);
    access("R7 P3 write C", 1, 3, ln(1, 3), 4, 0, 0, 0, 0);
    maint("R8 commit", 0, 0, 4'b0001, 1);
    access("R8 retired write gone", 0, 1, ln(1, 2), 2, 0, 0, 0, 0);
    access("R7 wrap P0 most spec", 0, 0, ln(1, 3), 4, 0, 1, 3, 0);
    access("R8 source after commit", 0, 2, ln(1, 1), 3, 0, 1, 1, 0);
  endtask

  task automatic t_squash();
    maint("R9 squash P2", 1, 2, 4'b1101, 1);
    access("R9 squashed write gone", 0, 1, ln(1, 3), 4, 0, 0, 0, 0);
  endtask

  task automatic t_stall();
    for (int t = 1; t <= 8; t++) access("R6 fill", 0, 1, ln(t, 5), 0, 0, 0, 0, 0);
    access("R6 full read", 0, 1, ln(9, 5), 0, 1, 0, 0, 0);
    access("R6 full write", 1, 2, ln(9, 5), 1, 1, 0, 0, 0);
    access("R6 hit in full set", 0, 1, ln(3, 5), 0, 0, 0, 0, 0);
    maint("R8 commit P1", 0, 0, 4'b0010, 2);
    access("R8 freed way", 0, 3, ln(9, 5), 1, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load_source();
    t_raw();
    t_shield();
    t_no_squash();
    t_commit();
    t_squash();
    t_stall();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule